// File: doc/BRIEF.md
# Instruction cache with flash invalidate

This block is a read-only instruction cache. It has four ways per set, 128 sets and 32-byte lines, 16 KiB of instruction storage in all. The fetch side presents an address with a request strobe. One cycle later it receives either the addressed 32-bit instruction word or a miss indication. A miss tells the surrounding fetch logic to fetch the line from memory. The fetch logic then returns that line through the fill port as eight word beats, in any word order.

Each line keeps only a tag and a valid bit. There is no store path, and the block watches no other bus traffic. Software keeps the cache coherent with a single-cycle pulse that drops every valid bit at once. A replacement line goes to a way that already holds the same line if there is one. Otherwise it goes to a free way, and failing that to the way named by a three-bit tree pseudo-LRU kept per set.

Top module: `icache_flash`

## Requirements
- R1: Address fields are: word select is fetch_addr[4:2], set index is fetch_addr[11:5], tag is fetch_addr[31:12]. A fetch_req sampled at a clock edge produces rsp_valid=1 after that same edge, and rsp_valid=0 after an edge with no request. On a hit, rsp_hit=1 and rsp_instr holds the word last written to that word slot of the line.
- R2: A fetch whose tag matches no valid way of its set responds with rsp_valid=1, rsp_hit=0 and rsp_instr=0.
- R3: A fill beat with fill_start=1 opens a fill for the line given by fill_addr and writes fill_data into word slot fill_addr[4:2]. Following beats with fill_start=0 write their word slots of that same line, and only their fill_addr[4:2] is used. The line becomes valid only in the cycle its eighth distinct word is written. Fetches to it miss until that edge.
- R4: A fill beat with fill_start=0 while no fill is open has no effect.
- R5: The way receiving a fill is chosen at the start beat. It is the way already holding the line if that line is resident. Otherwise it is the lowest-numbered invalid way, and otherwise the pseudo-LRU way. A set never holds two valid copies of one line.
- R6: The per-set pseudo-LRU state has three bits, p[0] to p[2], and is cleared by reset. The victim is way 0 or 1 when p[0]=0, chosen by p[1] (0 gives way 0, 1 gives way 1). When p[0]=1 it is way 2 or 3, chosen by p[2] (0 gives way 2, 1 gives way 3). A hit and a completed fill both mark their way as used: way 0 sets p[0]=1 and p[1]=1, way 1 sets p[0]=1 and p[1]=0, way 2 sets p[0]=0 and p[2]=1, way 3 sets p[0]=0 and p[2]=0. If a hit and a fill completion fall in the same set and cycle, the hit is applied first.
- R7: A cycle with inval_all=1 clears every valid bit at that edge, so every fetch from the next cycle on misses until a new fill completes.
- R8: inval_all has priority over fill: a fill beat in the same cycle is dropped, an open fill is closed, and later beats with fill_start=0 are ignored.
- R9: A fetch issued in a cycle with inval_all=1 responds as a miss.
- R10: After reset every fetch misses and all response outputs are 0 until the first request.
- R11: The start beat invalidates the chosen way's previous line at once, so a fetch to that old line misses from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_req | input | 1 | Fetch request strobe |
| fetch_addr | input | 32 | Fetch byte address |
| fill_valid | input | 1 | Fill beat present |
| fill_start | input | 1 | Beat opens a new line fill |
| fill_addr | input | 32 | Line address of the fill; bits [4:2] pick the word slot |
| fill_data | input | 32 | Instruction word of the beat |
| inval_all | input | 1 | Single-cycle invalidate of the whole cache |
| rsp_valid | output | 1 | Response to the previous cycle's fetch |
| rsp_hit | output | 1 | Response is a hit |
| rsp_instr | output | 32 | Instruction word on a hit, zero otherwise |

## Verification
Most internal faults in this block surface at the ports one cycle after a fetch of the affected line. A valid bit set too early gives a hit with stale or missing words during a fill. A valid bit surviving an invalidate gives a hit where a miss is due. A wrong victim or tree update evicts the wrong line. That last fault stays hidden until a later fill to the same set: the evicted line then misses, or the line that should have gone still hits. The bench therefore keeps an independent model of tags, valid bits and tree state. It compares every response against it while random traffic keeps four sets crowded with five competing tags.

// File: rtl/icf_pkg.sv
package icf_pkg;
  localparam int WAYS  = 4;
  localparam int WAY_W = 2;

  typedef logic [WAY_W-1:0] way_t;
  typedef logic [2:0]       plru_t;

  // Tree walk: bit 0 picks the pair, bits 1/2 pick within the pair.
  function automatic way_t plru_pick(plru_t p);
    if (!p[0]) return p[1] ? way_t'(1) : way_t'(0);
    else       return p[2] ? way_t'(3) : way_t'(2);
  endfunction

  // Point the tree away from the way just used.
  function automatic plru_t plru_touch(plru_t p, way_t w);
    plru_t n;
    n = p;
    case (w)
      2'd0:    begin n[0] = 1'b1; n[1] = 1'b1; end
      2'd1:    begin n[0] = 1'b1; n[1] = 1'b0; end
      2'd2:    begin n[0] = 1'b0; n[2] = 1'b1; end
      default: begin n[0] = 1'b0; n[2] = 1'b0; end
    endcase
    return n;
  endfunction
endpackage

// File: rtl/icf_tag_array.sv
module icf_tag_array
  import icf_pkg::*;
#(
  parameter int SETS  = 128,
  parameter int TAG_W = 20,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_set,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_hit,
  output way_t             rd_way,
  input  logic [SET_W-1:0] vic_set,
  input  logic [TAG_W-1:0] vic_tag,
  output way_t             vic_way,
  input  logic             flush,
  input  logic             claim_en,
  input  logic [SET_W-1:0] claim_set,
  input  way_t             claim_way,
  input  logic             commit_en,
  input  logic [SET_W-1:0] commit_set,
  input  way_t             commit_way,
  input  logic [TAG_W-1:0] commit_tag,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  way_t             touch_way
);

  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  valid_d [SETS];
  plru_t            plru_q  [SETS];
  plru_t            plru_d  [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];

  logic [WAYS-1:0] rd_match;
  logic [WAYS-1:0] vic_match;
  logic [WAYS-1:0] vic_valid;

  // Lookup and victim choice, both from the pre-edge state.
  always_comb begin
    vic_valid = valid_q[vic_set];
    for (int w = 0; w < WAYS; w++) begin
      rd_match[w]  = valid_q[rd_set][w] && (tag_q[rd_set][w] == rd_tag);
      vic_match[w] = vic_valid[w] && (tag_q[vic_set][w] == vic_tag);
    end
    rd_hit = |rd_match;
    rd_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (rd_match[w]) rd_way = way_t'(w);
    if (|vic_match) begin
      vic_way = '0;
      for (int w = WAYS - 1; w >= 0; w--)
        if (vic_match[w]) vic_way = way_t'(w);
    end else if (!(&vic_valid)) begin
      vic_way = '0;
      for (int w = WAYS - 1; w >= 0; w--)
        if (!vic_valid[w]) vic_way = way_t'(w);
    end else begin
      vic_way = plru_pick(plru_q[vic_set]);
    end
  end

  // Next state: invalidate dominates claim and commit.
  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      valid_d[s] = valid_q[s];
      plru_d[s]  = plru_q[s];
      if (claim_en && claim_set == SET_W'(s))
        valid_d[s][claim_way] = 1'b0;
      if (commit_en && commit_set == SET_W'(s)) begin
        valid_d[s][commit_way] = 1'b1;
      end
      if (flush)
        valid_d[s] = '0;
      if (touch_en && touch_set == SET_W'(s))
        plru_d[s] = plru_touch(plru_d[s], touch_way);
      if (commit_en && commit_set == SET_W'(s))
        plru_d[s] = plru_touch(plru_d[s], commit_way);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        plru_q[s]  <= '0;
      end
    end else begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= valid_d[s];
        plru_q[s]  <= plru_d[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (commit_en)
      tag_q[commit_set][commit_way] <= commit_tag;
  end

  // R5: fills reuse a resident way, so at most one way ever matches.
  p_single_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_match));

  // R5: with a free way and no resident copy, the victim is a free way.
  p_victim_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|vic_match) && !(&vic_valid)) |-> !vic_valid[vic_way]);

  // R7 / R8: the cycle after an invalidate nothing can hit.
  p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !rd_hit);

endmodule

// File: rtl/icf_data_array.sv
module icf_data_array
  import icf_pkg::*;
#(
  parameter int SETS       = 128,
  parameter int LINE_WORDS = 8,
  parameter int WORD_W     = 32,
  localparam int SET_W  = $clog2(SETS),
  localparam int WSEL_W = $clog2(LINE_WORDS),
  localparam int LINE_W = LINE_WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  way_t              wr_way,
  input  logic [WSEL_W-1:0] wr_word,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [SET_W-1:0]  rd_set,
  input  way_t              rd_way,
  input  logic [WSEL_W-1:0] rd_word,
  output logic [WORD_W-1:0] rd_data
);

  logic [LINE_W-1:0] way_line [WAYS];

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    logic [LINE_W-1:0] line_q [SETS];

    always_ff @(posedge clk) begin
      if (wr_en && wr_way == way_t'(g))
        line_q[wr_set][wr_word*WORD_W +: WORD_W] <= wr_data;
    end

    assign way_line[g] = line_q[rd_set];
  end

  assign rd_data = way_line[rd_way][rd_word*WORD_W +: WORD_W];

endmodule

// File: rtl/icf_fill_ctrl.sv
module icf_fill_ctrl
  import icf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 128,
  parameter int LINE_WORDS = 8,
  parameter int WORD_W     = 32,
  localparam int SET_W  = $clog2(SETS),
  localparam int WSEL_W = $clog2(LINE_WORDS),
  localparam int OFF_W  = $clog2(LINE_WORDS * WORD_W / 8),
  localparam int BYTE_W = OFF_W - WSEL_W,
  localparam int TAG_W  = ADDR_W - SET_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_valid,
  input  logic              fill_start,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              flush,
  input  way_t              vic_way,
  output logic [SET_W-1:0]  vic_set,
  output logic [TAG_W-1:0]  vic_tag,
  output logic              claim_en,
  output logic              wr_en,
  output logic [SET_W-1:0]  wr_set,
  output way_t              wr_way,
  output logic [WSEL_W-1:0] wr_word,
  output logic              commit_en,
  output logic [TAG_W-1:0]  commit_tag
);

  logic                  active_q, active_d;
  logic [SET_W-1:0]      set_q;
  logic [TAG_W-1:0]      tag_q;
  way_t                  way_q;
  logic [LINE_WORDS-1:0] mask_q, mask_d, mask_n;
  logic                  start_ok, cont_ok;
  logic                  unused_fill_bits;

  assign unused_fill_bits = ^fill_addr[BYTE_W-1:0];
  assign vic_set = fill_addr[OFF_W +: SET_W];
  assign vic_tag = fill_addr[ADDR_W-1 -: TAG_W];

  always_comb begin
    start_ok   = fill_valid && fill_start && !flush;
    cont_ok    = fill_valid && !fill_start && active_q && !flush;
    claim_en   = start_ok;
    wr_en      = start_ok || cont_ok;
    wr_set     = start_ok ? vic_set : set_q;
    wr_way     = start_ok ? vic_way : way_q;
    wr_word    = fill_addr[OFF_W-1:BYTE_W];
    mask_n     = (start_ok ? '0 : mask_q) | (LINE_WORDS'(1) << wr_word);
    commit_en  = wr_en && (&mask_n);
    commit_tag = start_ok ? vic_tag : tag_q;

    active_d = active_q;
    mask_d   = mask_q;
    if (flush) begin
      active_d = 1'b0;
      mask_d   = '0;
    end else if (wr_en) begin
      active_d = !commit_en;
      mask_d   = commit_en ? '0 : mask_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      mask_q   <= '0;
    end else begin
      active_q <= active_d;
      mask_q   <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q <= '0;
      tag_q <= '0;
      way_q <= '0;
    end else if (start_ok) begin
      set_q <= vic_set;
      tag_q <= vic_tag;
      way_q <= vic_way;
    end
  end

  // R8: an invalidate always leaves no fill open.
  p_flush_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !active_q);

  // R3: a start beat that does not finish the line leaves a fill open.
  p_start_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_en && !commit_en) |=> active_q);

  // R3: a finished line closes the fill.
  p_commit_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |=> !active_q);

endmodule

// File: rtl/icache_flash.sv
module icache_flash
  import icf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 128,
  parameter int LINE_WORDS = 8,
  parameter int WORD_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              fill_valid,
  input  logic              fill_start,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [WORD_W-1:0] fill_data,
  input  logic              inval_all,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WORD_W-1:0] rsp_instr
);

  localparam int SET_W  = $clog2(SETS);
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int OFF_W  = $clog2(LINE_WORDS * WORD_W / 8);
  localparam int BYTE_W = OFF_W - WSEL_W;
  localparam int TAG_W  = ADDR_W - SET_W - OFF_W;

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic [SET_W-1:0]  f_set;
  logic [TAG_W-1:0]  f_tag;
  logic [WSEL_W-1:0] f_word;
  logic              unused_fetch_bits;

  assign f_word            = fetch_addr[OFF_W-1:BYTE_W];
  assign f_set             = fetch_addr[OFF_W +: SET_W];
  assign f_tag             = fetch_addr[ADDR_W-1 -: TAG_W];
  assign unused_fetch_bits = ^fetch_addr[BYTE_W-1:0];

  logic              lk_hit;
  way_t              lk_way;
  logic              hit_ok;
  logic [WORD_W-1:0] rd_word_data;

  logic [SET_W-1:0]  vic_set;
  logic [TAG_W-1:0]  vic_tag;
  way_t              vic_way;
  logic              claim_en, wr_en, commit_en;
  logic [SET_W-1:0]  wr_set;
  way_t              wr_way;
  logic [WSEL_W-1:0] wr_word;
  logic [TAG_W-1:0]  commit_tag;

  assign hit_ok = fetch_req && lk_hit && !inval_all;

  icf_fill_ctrl #(
    .ADDR_W(ADDR_W), .SETS(SETS), .LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W)
  ) u_fill (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .fill_valid(fill_valid),
    .fill_start(fill_start),
    .fill_addr (fill_addr),
    .flush     (inval_all),
    .vic_way   (vic_way),
    .vic_set   (vic_set),
    .vic_tag   (vic_tag),
    .claim_en  (claim_en),
    .wr_en     (wr_en),
    .wr_set    (wr_set),
    .wr_way    (wr_way),
    .wr_word   (wr_word),
    .commit_en (commit_en),
    .commit_tag(commit_tag)
  );

  icf_tag_array #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rd_set    (f_set),
    .rd_tag    (f_tag),
    .rd_hit    (lk_hit),
    .rd_way    (lk_way),
    .vic_set   (vic_set),
    .vic_tag   (vic_tag),
    .vic_way   (vic_way),
    .flush     (inval_all),
    .claim_en  (claim_en),
    .claim_set (wr_set),
    .claim_way (wr_way),
    .commit_en (commit_en),
    .commit_set(wr_set),
    .commit_way(wr_way),
    .commit_tag(commit_tag),
    .touch_en  (hit_ok),
    .touch_set (f_set),
    .touch_way (lk_way)
  );

  icf_data_array #(.SETS(SETS), .LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W)) u_data (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_set (wr_set),
    .wr_way (wr_way),
    .wr_word(wr_word),
    .wr_data(fill_data),
    .rd_set (f_set),
    .rd_way (lk_way),
    .rd_word(f_word),
    .rd_data(rd_word_data)
  );

  // Response stage.
  logic              rsp_valid_d, rsp_hit_d;
  logic [WORD_W-1:0] rsp_instr_d;

  always_comb begin
    rsp_valid_d = fetch_req;
    rsp_hit_d   = hit_ok;
    rsp_instr_d = hit_ok ? rd_word_data : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_instr <= '0;
    end else begin
      rsp_valid <= rsp_valid_d;
      if (fetch_req) begin
        rsp_hit   <= rsp_hit_d;
        rsp_instr <= rsp_instr_d;
      end else begin
        rsp_hit   <= 1'b0;
      end
    end
  end

  // R1: every request gets exactly one response in the next cycle.
  p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fetch_req |=> rsp_valid);
  p_no_rsp_idle_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !fetch_req |=> !rsp_valid && !rsp_hit);

  // R9: a fetch in an invalidate cycle is a miss.
  p_miss_in_flush_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fetch_req && inval_all) |=> (rsp_valid && !rsp_hit));

  // R2: a miss never carries data.
  p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid && !rsp_hit) |-> (rsp_instr == '0));

endmodule

// File: tb/icache_flash_tb.sv
module icache_flash_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSETS = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_req = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        fill_valid = 1'b0;
  logic        fill_start = 1'b0;
  logic [31:0] fill_addr = '0;
  logic [31:0] fill_data = '0;
  logic        inval_all = 1'b0;
  logic        rsp_valid, rsp_hit;
  logic [31:0] rsp_instr;

  always #(CLK_PERIOD/2) clk = ~clk;

  icache_flash u_dut (
    .clk(clk), .rst_n(rst_n),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fill_valid(fill_valid), .fill_start(fill_start),
    .fill_addr(fill_addr), .fill_data(fill_data),
    .inval_all(inval_all),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_instr(rsp_instr)
  );

  int n_cmp = 0;
  int n_bad = 0;
  string req_s = "R10";

  // Independent reference state.
  bit           mv [NSETS][4];
  logic [19:0]  mt [NSETS][4];
  logic [255:0] md [NSETS][4];
  logic [2:0]   mp [NSETS];
  bit           m_act;
  int           m_set, m_way;
  logic [19:0]  m_tag;
  logic [7:0]   m_mask;

  function automatic logic [31:0] mkaddr(int tag, int set, int word);
    return {tag[19:0], set[6:0], word[2:0], 2'b00};
  endfunction

  function automatic int m_lookup(int set, logic [19:0] tag);
    for (int w = 0; w < 4; w++)
      if (mv[set][w] && mt[set][w] == tag) return w;
    return -1;
  endfunction

  function automatic int m_victim(int set, logic [19:0] tag);
    int w;
    w = m_lookup(set, tag);
    if (w >= 0) return w;
    for (int i = 0; i < 4; i++) if (!mv[set][i]) return i;
    if (!mp[set][0]) return mp[set][1] ? 1 : 0;
    return mp[set][2] ? 3 : 2;
  endfunction

  function automatic logic [2:0] m_touch(logic [2:0] p, int w);
    logic [2:0] n;
    n = p;
    case (w)
      0: begin n[0] = 1; n[1] = 1; end
      1: begin n[0] = 1; n[1] = 0; end
      2: begin n[0] = 0; n[2] = 1; end
      default: begin n[0] = 0; n[2] = 0; end
    endcase
    return n;
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req_s, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // One cycle: drive at the falling edge, advance the model, check after the next falling edge.
  task automatic step(bit req, logic [31:0] fa, bit fv, bit fs, logic [31:0] fad,
                      logic [31:0] fd, bit fl);
    int fset, fword, hw, vset, vw, wd;
    logic [19:0] ftag, vtag;
    bit exp_hit;
    logic [31:0] exp_data;
    fetch_req = req; fetch_addr = fa;
    fill_valid = fv; fill_start = fs; fill_addr = fad; fill_data = fd;
    inval_all = fl;
    fset = int'(fa[11:5]); fword = int'(fa[4:2]); ftag = fa[31:12];
    vset = int'(fad[11:5]); vtag = fad[31:12]; wd = int'(fad[4:2]);
    hw = req ? m_lookup(fset, ftag) : -1;
    if (fl) hw = -1;
    exp_hit = (hw >= 0);
    exp_data = exp_hit ? md[fset][hw][fword*32 +: 32] : 32'h0;
    vw = m_victim(vset, vtag);
    if (exp_hit) mp[fset] = m_touch(mp[fset], hw);
    if (fl) begin
      for (int s = 0; s < NSETS; s++) for (int w = 0; w < 4; w++) mv[s][w] = 0;
      m_act = 0;
    end else if (fv && fs) begin
      m_set = vset; m_tag = vtag; m_way = vw;
      mv[m_set][m_way] = 0;
      md[m_set][m_way][wd*32 +: 32] = fd;
      m_mask = 8'(1 << wd);
      m_act = 1;
    end else if (fv && m_act) begin
      md[m_set][m_way][wd*32 +: 32] = fd;
      m_mask = m_mask | 8'(1 << wd);
      if (m_mask == 8'hFF) begin
        mv[m_set][m_way] = 1;
        mt[m_set][m_way] = m_tag;
        mp[m_set] = m_touch(mp[m_set], m_way);
        m_act = 0;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk("rsp_valid", {31'b0, rsp_valid}, {31'b0, req});
    if (req) begin
      chk("rsp_hit", {31'b0, rsp_hit}, {31'b0, exp_hit});
      chk("rsp_instr", rsp_instr, exp_data);
    end
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic fetch(int tag, int set, int word);
    step(1, mkaddr(tag, set, word), 0, 0, 0, 0, 0);
  endtask

  task automatic beat(int tag, int set, int word, bit first);
    step(0, 0, 1, first, mkaddr(tag, set, word), $urandom, 0);
  endtask

  // Full fill, critical word first starting at w0.
  task automatic fill_line(int tag, int set, int w0);
    for (int i = 0; i < 8; i++) beat(tag, set, (w0 + i) % 8, i == 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int rf_left, rf_tag, rf_set, rf_w;
    int pool [4];
    void'($urandom(32'd2024));
    pool[0] = 0; pool[1] = 1; pool[2] = 2; pool[3] = 127;
    for (int s = 0; s < NSETS; s++) begin
      mp[s] = 0;
      for (int w = 0; w < 4; w++) mv[s][w] = 0;
    end
    m_act = 0; m_mask = 0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: response outputs clear after reset, nothing hits.
    req_s = "R10";
    chk("rsp_valid reset", {31'b0, rsp_valid}, 32'd0);
    chk("rsp_hit reset", {31'b0, rsp_hit}, 32'd0);
    chk("rsp_instr reset", rsp_instr, 32'd0);
    fetch(0, 0, 0); fetch(7, 127, 5);

    // R3: line invisible while partly filled, then R1 hits on every word.
    req_s = "R3";
    for (int i = 0; i < 5; i++) beat(1, 5, (3 + i) % 8, i == 0);
    fetch(1, 5, 3); fetch(1, 5, 4);
    for (int i = 5; i < 8; i++) beat(1, 5, (3 + i) % 8, 0);
    req_s = "R1";
    for (int w = 0; w < 8; w++) fetch(1, 5, w);
    req_s = "R2";
    fetch(2, 5, 0); fetch(1, 6, 0);

    // R4: stray beats without an open fill leave nothing behind.
    req_s = "R4";
    for (int w = 0; w < 8; w++) beat(2, 6, w, 0);
    fetch(2, 6, 0); fetch(2, 6, 7);

    // R5 and R6: fill four free ways, steer the tree, then evict.
    req_s = "R5";
    for (int t = 10; t < 14; t++) fill_line(t, 9, t % 8);
    for (int t = 10; t < 14; t++) fetch(t, 9, 1);
    req_s = "R6";
    fetch(10, 9, 2); fetch(12, 9, 2);
    fill_line(14, 9, 0);
    for (int t = 10; t < 15; t++) fetch(t, 9, 6);
    req_s = "R5";
    fill_line(11, 9, 4);
    for (int t = 10; t < 15; t++) fetch(t, 9, 4);

    // R11: the start beat drops the victim's old line at once.
    req_s = "R11";
    beat(15, 9, 0, 1);
    for (int t = 10; t < 16; t++) fetch(t, 9, 0);
    for (int w = 1; w < 8; w++) beat(15, 9, w, 0);
    fetch(15, 9, 7);

    // R7: one invalidate pulse empties the whole cache.
    req_s = "R7";
    step(0, 0, 0, 0, 0, 0, 1);
    fetch(1, 5, 0); fetch(15, 9, 7); fetch(13, 9, 0);

    // R8: invalidate beats a fill, and the leftover beats are ignored.
    req_s = "R8";
    for (int i = 0; i < 3; i++) beat(20, 30, i, i == 0);
    step(0, 0, 1, 0, mkaddr(20, 30, 3), 32'h1234, 1);
    for (int w = 4; w < 8; w++) beat(20, 30, w, 0);
    fetch(20, 30, 0);
    for (int i = 0; i < 7; i++) beat(21, 30, i, i == 0);
    step(0, 0, 1, 0, mkaddr(21, 30, 7), 32'h5678, 1);
    fetch(21, 30, 7);

    // R9: a fetch during the invalidate cycle misses even on a resident line.
    req_s = "R9";
    fill_line(22, 31, 2);
    fetch(22, 31, 2);
    step(1, mkaddr(22, 31, 2), 0, 0, 0, 0, 1);
    fetch(22, 31, 2);
    idle();

    // Random traffic over four crowded sets.
    req_s = "R5 random";
    rf_left = 0; rf_tag = 0; rf_set = 0; rf_w = 0;
    for (int c = 0; c < 6000; c++) begin
      bit req, fv, fs, fl;
      logic [31:0] fa, fad;
      req = ($urandom % 10) < 6;
      fa = mkaddr($urandom % 5, pool[$urandom % 4], $urandom % 8);
      fl = ($urandom % 150) == 0;
      fv = 0; fs = 0; fad = 0;
      if (rf_left == 0 && ($urandom % 8) == 0) begin
        rf_tag = $urandom % 5; rf_set = pool[$urandom % 4]; rf_w = $urandom % 8;
        fv = 1; fs = 1; fad = mkaddr(rf_tag, rf_set, rf_w); rf_left = 7;
      end else if (rf_left > 0 && ($urandom % 10) < 7) begin
        rf_w = (rf_w + 1) % 8;
        fv = 1; fs = (($urandom % 60) == 0); fad = mkaddr(rf_tag, rf_set, rf_w);
        rf_left = fs ? 7 : rf_left - 1;
      end else if (rf_left == 0 && ($urandom % 40) == 0) begin
        fv = 1; fad = mkaddr($urandom % 5, pool[$urandom % 4], $urandom % 8);
      end
      if (fl) rf_left = 0;
      step(req, fa, fv, fs, fad, $urandom, fl);
    end

    summary();
    $finish;
  end
endmodule